// File: doc/BRIEF.md
# Multi-core interrupt controller

This block collects interrupts for a small group of processor cores and delivers one interrupt request line to each core. Interrupt IDs fall into three ranges. IDs 0 to 15 are software interrupts: a core raises them on itself or on other cores by writing a send register. IDs 16 to 31 are private to each core and come from per-core level inputs. IDs 32 and up are common interrupts: they come from shared level inputs, and each one is steered to a single destination core.

Software reaches the block through a simple register port. The port accepts one access per cycle and returns read data in the following cycle. The address space has one global region at the bottom, 0x8000 bytes long. The local region of core n starts at 0x8000 + n×0x1000. Software uses its core's local region to do the following:
- switch that core's delivery on and off;
- read the most urgent pending ID;
- acknowledge (take) that ID;
- enable, disable or complete an ID by writing the ID value to a dedicated register.

Among the eligible IDs of a core, the lowest ID always wins. Taking an ID makes it active, and an active ID is not presented again until software writes its completion.

Top module: `mcirq_ctrl`

## Requirements
- R1: After reset, every core request output is 0, every register reads 0, and an acknowledge read returns 1023.
- R2: A core is offered interrupts only while bit 0 of the global control word (global offset 0x0) is 1 and bit 0 of that core's local control word (local offset 0x0) is 1.
- R3: A write to local offset 0x60 latches software ID bits [3:0] as pending on every core whose bit is set in the mask field bits [15:8] (bit 8 is core 0). The pending bit stays set until that core takes the ID.
- R4: Writing an ID in bits [9:0] to local offset 0xA0 enables it, and writing an ID to offset 0xA4 disables it. IDs below 32 are enabled per core. Common IDs share one enable. A disabled ID is never offered, and a write of an ID above the last common ID has no effect.
- R5: When several IDs are eligible on a core, the lowest ID is the one offered.
- R6: A read of local offset 0x6C returns the offered ID in bits [9:0], or 1023 if none is offered. If an ID was offered, the read marks it active and clears its software pending bit.
- R7: An active ID is not offered again until its ID is written to local offset 0xB4. A level input still high at that completion is offered again.
- R8: A read of local offset 0x68 returns 1 in bit 31 when an ID is offered and the offered ID (or 1023) in bits [9:0]. The core's request output equals that bit 31.
- R9: The destination word of common ID k is at global offset 0x1000 + 4×(k−32). Its bits [3:0] name the target core and bit 31 enables delivery. Common ID k reaches only that core, and reaches no core when bit 31 is 0.
- R10: Private ID 16+i of core c is driven by input bit `priv_irq[c*16+i]` and is seen only by core c.
- R11: A read of an address with no register returns 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| priv_irq | input | NUM_CORES*16 | Private level inputs, 16 per core |
| com_irq | input | NUM_COMMON | Common level inputs |
| core_irq | output | NUM_CORES | Interrupt request to each core |

## Verification
The hardest situation to reach is a common interrupt that has been taken while its input level stays high. In that state, its routing, its enable and the completion writes must all interact correctly. Taking a software interrupt that was sent again while still active is a similar case. Directed sequences build these cases explicitly. A long stretch of seeded random operations then interleaves the following, so that many such overlaps arise:
- sends;
- enables;
- completions;
- acknowledges;
- level toggles;
- destination rewrites.

A bench model predicts the winner on every core after each step.

// File: rtl/mcirq_pkg.sv
package mcirq_pkg;
    localparam int ID_W      = 10;
    localparam int SW_IDS    = 16;
    localparam int COM_BASE  = 32;
    localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;
    localparam logic [31:0] GLOB_SPAN = 32'h8000;
    localparam logic [31:0] DEST_BASE = 32'h1000;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_GCTL,
        RK_DEST,
        RK_LCTL,
        RK_SEND,
        RK_PEND,
        RK_ACK,
        RK_ENSET,
        RK_ENCLR,
        RK_EOI
    } reg_kind_e;
endpackage

// File: rtl/mcirq_decode.sv
module mcirq_decode
    import mcirq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_CORES  = 2,
    parameter int NUM_COMMON = 8,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int COM_W  = (NUM_COMMON > 1) ? $clog2(NUM_COMMON) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [CORE_W-1:0] core,
    output logic [COM_W-1:0]  com_idx
);
    logic [31:0] a32;
    logic [31:0] loff;
    logic [31:0] cnum;

    always_comb begin
        a32     = 32'(addr);
        loff    = a32 - GLOB_SPAN;
        cnum    = loff >> 12;
        kind    = RK_NONE;
        core    = '0;
        com_idx = '0;
        if (a32 < GLOB_SPAN) begin
            if (a32 == 32'h0) begin
                kind = RK_GCTL;
            end else if (a32 >= DEST_BASE && a32 < DEST_BASE + 32'(4 * NUM_COMMON)
                         && a32[1:0] == 2'b00) begin
                kind    = RK_DEST;
                com_idx = COM_W'((a32 - DEST_BASE) >> 2);
            end
        end else if (cnum < 32'(NUM_CORES)) begin
            core = CORE_W'(cnum);
            unique case (loff[11:0])
                12'h000: kind = RK_LCTL;
                12'h060: kind = RK_SEND;
                12'h068: kind = RK_PEND;
                12'h06C: kind = RK_ACK;
                12'h0A0: kind = RK_ENSET;
                12'h0A4: kind = RK_ENCLR;
                12'h0B4: kind = RK_EOI;
                default: kind = RK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mcirq_select.sv
module mcirq_select
    import mcirq_pkg::*;
#(
    parameter int N_REQ = 40
) (
    input  logic [N_REQ-1:0] req,
    output logic             hit,
    output logic [ID_W-1:0]  win
);
    always_comb begin
        hit = 1'b0;
        win = NO_IRQ;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                win = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/mcirq_ctrl.sv
module mcirq_ctrl
    import mcirq_pkg::*;
#(
    parameter int NUM_CORES  = 2,
    parameter int NUM_COMMON = 8,
    parameter int ADDR_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_CORES*16-1:0] priv_irq,
    input  logic [NUM_COMMON-1:0]   com_irq,
    output logic [NUM_CORES-1:0]    core_irq
);
    localparam int TOT    = COM_BASE + NUM_COMMON;
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int COM_W  = (NUM_COMMON > 1) ? $clog2(NUM_COMMON) : 1;
    localparam int SEL_W  = $clog2(TOT);
    localparam logic [TOT-1:0] ONE = TOT'(1);

    reg_kind_e          dec_kind;
    logic [CORE_W-1:0]  dcore;
    logic [COM_W-1:0]   dcom;

    logic                               glob_en;
    logic [NUM_CORES-1:0]               loc_en;
    logic [NUM_CORES-1:0][SW_IDS-1:0]   sw_pend;
    logic [NUM_CORES-1:0][31:0]         en_loc;
    logic [NUM_CORES-1:0][31:0]         act_loc;
    logic [NUM_COMMON-1:0]              com_en;
    logic [NUM_COMMON-1:0]              com_act;
    logic [NUM_COMMON-1:0]              dest_on;
    logic [NUM_COMMON-1:0][3:0]         dest_core;

    logic [NUM_CORES-1:0] sel_hit;
    logic [ID_W-1:0]      sel_id [NUM_CORES];

    logic [ID_W-1:0]  wid;
    logic [COM_W-1:0] wcidx;
    logic [ID_W-1:0]  ack_id;
    logic [COM_W-1:0] ack_cidx;
    logic             ack_fire;
    logic [31:0]      rd_next;
    logic             unused_wbits;

    mcirq_decode #(
        .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .NUM_COMMON(NUM_COMMON)
    ) u_decode (
        .addr(bus_addr), .kind(dec_kind), .core(dcore), .com_idx(dcom)
    );

    assign wid          = bus_wdata[ID_W-1:0];
    assign wcidx        = COM_W'(wid - 10'd32);
    assign ack_id       = sel_id[dcore];
    assign ack_cidx     = COM_W'(ack_id - 10'd32);
    assign ack_fire     = bus_en && !bus_we && (dec_kind == RK_ACK);
    assign unused_wbits = ^{bus_wdata[30:16], bus_wdata[15:8], bus_wdata[7:4]};
    assign core_irq     = sel_hit;

    // Per-core eligibility and lowest-ID selection
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [TOT-1:0]   req;
        logic [SEL_W-1:0] win_idx;

        always_comb begin
            req = '0;
            if (glob_en && loc_en[c]) begin
                req[15:0]  = sw_pend[c] & en_loc[c][15:0] & ~act_loc[c][15:0];
                req[31:16] = priv_irq[c*16 +: 16] & en_loc[c][31:16] & ~act_loc[c][31:16];
                for (int k = 0; k < NUM_COMMON; k++) begin
                    req[COM_BASE+k] = com_irq[k] & com_en[k] & ~com_act[k]
                                      & dest_on[k] & (dest_core[k] == 4'(c));
                end
            end
        end

        mcirq_select #(.N_REQ(TOT)) u_sel (
            .req(req), .hit(sel_hit[c]), .win(sel_id[c])
        );

        assign win_idx = sel_id[c][SEL_W-1:0];

        // R5: no eligible ID below the winner, and the winner itself is eligible
        assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sel_hit[c] |-> (((req & ((ONE << sel_id[c]) - ONE)) == '0) && req[win_idx]));

        // R3: a send with this core's mask bit leaves the ID pending here
        assert_send_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_en && bus_we && dec_kind == RK_SEND && bus_wdata[8+c])
            |=> sw_pend[c][$past(bus_wdata[3:0])]);
    end

    // Register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_en   <= 1'b0;
            loc_en    <= '0;
            sw_pend   <= '0;
            en_loc    <= '0;
            act_loc   <= '0;
            com_en    <= '0;
            com_act   <= '0;
            dest_on   <= '0;
            dest_core <= '0;
        end else if (bus_en && bus_we) begin
            unique case (dec_kind)
                RK_GCTL: glob_en <= bus_wdata[0];
                RK_DEST: begin
                    dest_core[dcom] <= bus_wdata[3:0];
                    dest_on[dcom]   <= bus_wdata[31];
                end
                RK_LCTL: loc_en[dcore] <= bus_wdata[0];
                RK_SEND: begin
                    for (int c = 0; c < NUM_CORES; c++) begin
                        if (bus_wdata[8+c]) sw_pend[c][bus_wdata[3:0]] <= 1'b1;
                    end
                end
                RK_ENSET: begin
                    if (wid < 10'd32)          en_loc[dcore][wid[4:0]] <= 1'b1;
                    else if (wid < 10'(TOT))   com_en[wcidx]           <= 1'b1;
                end
                RK_ENCLR: begin
                    if (wid < 10'd32)          en_loc[dcore][wid[4:0]] <= 1'b0;
                    else if (wid < 10'(TOT))   com_en[wcidx]           <= 1'b0;
                end
                RK_EOI: begin
                    if (wid < 10'd32)          act_loc[dcore][wid[4:0]] <= 1'b0;
                    else if (wid < 10'(TOT))   com_act[wcidx]           <= 1'b0;
                end
                default: ;
            endcase
        end else if (ack_fire && sel_hit[dcore]) begin
            if (ack_id < 10'd16) begin
                sw_pend[dcore][ack_id[3:0]] <= 1'b0;
                act_loc[dcore][ack_id[4:0]] <= 1'b1;
            end else if (ack_id < 10'd32) begin
                act_loc[dcore][ack_id[4:0]] <= 1'b1;
            end else begin
                com_act[ack_cidx] <= 1'b1;
            end
        end
    end

    // Read data
    always_comb begin
        unique case (dec_kind)
            RK_GCTL: rd_next = {31'b0, glob_en};
            RK_DEST: rd_next = {dest_on[dcom], 27'b0, dest_core[dcom]};
            RK_LCTL: rd_next = {31'b0, loc_en[dcore]};
            RK_PEND: rd_next = {sel_hit[dcore], 21'b0, sel_id[dcore]};
            RK_ACK:  rd_next = {22'b0, sel_id[dcore]};
            default: rd_next = 32'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_next;
    end

    // R6: taking a common ID makes it active
    assert_ack_common_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && sel_hit[dcore] && ack_id >= 10'd32) |=> com_act[$past(ack_cidx)]);

    // R6: taking a software ID clears its pending bit
    assert_ack_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && sel_hit[dcore] && ack_id < 10'd16)
        |=> !sw_pend[$past(dcore)][$past(ack_id[3:0])]);

    // R2: no request leaves while the controller is off
    assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (core_irq == '0));

    // R11: reads of unmapped addresses return zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && dec_kind == RK_NONE) |=> (bus_rdata == 32'b0));
endmodule

// File: tb/mcirq_ctrl_bench.sv
module mcirq_ctrl_bench;
    localparam int NC     = 2;
    localparam int NCOM   = 8;
    localparam int ADDR_W = 16;
    localparam int TOT    = 32 + NCOM;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC*16-1:0]  priv_irq = '0;
    logic [NCOM-1:0]   com_irq = '0;
    logic [NC-1:0]     core_irq;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Reference model state
    bit  m_glob;
    bit  m_loc [NC];
    bit  m_sw  [NC][16];
    bit  m_en  [NC][32];
    bit  m_act [NC][32];
    bit  m_cen [NCOM];
    bit  m_cact[NCOM];
    bit  m_don [NCOM];
    int  m_dcore[NCOM];

    always #5 clk = ~clk;

    mcirq_ctrl #(.NUM_CORES(NC), .NUM_COMMON(NCOM), .ADDR_W(ADDR_W)) u_mcirq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .priv_irq(priv_irq), .com_irq(com_irq), .core_irq(core_irq)
    );

    function automatic bit m_req(int c, int id);
        if (!m_glob || !m_loc[c]) return 1'b0;
        if (id < 16) return m_sw[c][id] && m_en[c][id] && !m_act[c][id];
        if (id < 32) return priv_irq[c*16 + id - 16] && m_en[c][id] && !m_act[c][id];
        return com_irq[id-32] && m_cen[id-32] && !m_cact[id-32]
               && m_don[id-32] && (m_dcore[id-32] == c);
    endfunction

    function automatic int m_win(int c);
        for (int id = 0; id < TOT; id++) if (m_req(c, id)) return id;
        return 1023;
    endfunction

    function automatic int lbase(int c);
        return 'h8000 + c * 'h1000;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_irq(string tag);
        #1;
        for (int c = 0; c < NC; c++) begin
            bit e = (m_win(c) != 1023);
            chk(core_irq[c] == e, tag, core_irq[c], e);
        end
    endtask

    task automatic set_glob(bit v);
        wr(0, {31'b0, v}); m_glob = v;
    endtask

    task automatic set_loc(int c, bit v);
        wr(lbase(c), {31'b0, v}); m_loc[c] = v;
    endtask

    task automatic do_send(int mask, int id);
        wr(lbase(0) + 'h60, 32'((mask << 8) | id));
        for (int c = 0; c < NC; c++) if (mask[c]) m_sw[c][id] = 1'b1;
    endtask

    task automatic do_en(int c, int id, bit on);
        wr(lbase(c) + (on ? 'hA0 : 'hA4), 32'(id));
        if (id < 32) m_en[c][id] = on;
        else if (id < TOT) m_cen[id-32] = on;
    endtask

    task automatic do_eoi(int c, int id);
        wr(lbase(c) + 'hB4, 32'(id));
        if (id < 32) m_act[c][id] = 1'b0;
        else if (id < TOT) m_cact[id-32] = 1'b0;
    endtask

    task automatic do_dest(int k, int core, bit on);
        wr('h1000 + 4 * k, {on, 27'b0, 4'(core)});
        m_dcore[k] = core; m_don[k] = on;
    endtask

    task automatic do_ack(int c, string tag);
        logic [31:0] v;
        int exp = m_win(c);
        rd(lbase(c) + 'h6C, v);
        chk(v == 32'(exp), tag, v, exp);
        if (exp != 1023) begin
            if (exp < 32) m_act[c][exp] = 1'b1;
            if (exp < 16) m_sw[c][exp] = 1'b0;
            if (exp >= 32) m_cact[exp-32] = 1'b1;
        end
    endtask

    task automatic do_pend(int c, string tag);
        logic [31:0] v;
        int w = m_win(c);
        logic [31:0] exp = {(w != 1023), 21'b0, 10'(w)};
        rd(lbase(c) + 'h68, v);
        chk(v == exp, tag, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_irq("R1");
        rd(0, v);                      chk(v == 0, "R1 global ctrl", v, 0);
        rd('h1004, v);                 chk(v == 0, "R1 dest word", v, 0);
        do_ack(0, "R1 ack idle");

        // R2: both enables gate delivery
        do_send(1, 3);
        do_en(0, 3, 1'b1);
        set_loc(0, 1'b1);
        check_irq("R2 global off");
        set_glob(1'b1);
        check_irq("R2 global on");
        chk(core_irq[0] == 1'b1, "R2 core0 raised", core_irq[0], 1);
        chk(core_irq[1] == 1'b0, "R2 core1 local off", core_irq[1], 0);

        // R3 / R5 / R6 / R8: send to both cores, lowest first
        do_send(3, 5);
        do_en(1, 5, 1'b1);
        set_loc(1, 1'b1);
        do_en(0, 5, 1'b1);
        check_irq("R3 both cores");
        do_pend(0, "R8 pending id 3");
        do_ack(1, "R3 core1 takes 5");
        do_ack(0, "R5 core0 takes 3 first");
        do_ack(0, "R5 core0 takes 5 next");
        do_ack(0, "R6 nothing left");
        do_pend(0, "R8 none pending");
        check_irq("R8 idle");

        // R7: active software ID blocks a resend until completion
        do_send(1, 3);
        check_irq("R7 resend while active");
        chk(core_irq[0] == 1'b0, "R7 blocked", core_irq[0], 0);
        do_eoi(0, 3);
        check_irq("R7 after completion");
        do_ack(0, "R7 retake 3");
        do_eoi(0, 3);
        do_eoi(0, 5);
        do_eoi(1, 5);

        // R4: enable and disable by ID
        do_en(0, 60, 1'b1);
        do_send(1, 7);
        check_irq("R4 not enabled");
        do_en(0, 7, 1'b1);
        check_irq("R4 enabled");
        do_en(0, 7, 1'b0);
        check_irq("R4 disabled");
        chk(core_irq[0] == 1'b0, "R4 disabled output", core_irq[0], 0);
        do_en(0, 7, 1'b1);
        do_ack(0, "R4 take 7");
        do_eoi(0, 7);

        // R9 / R7: common routing and level re-presentation
        do_dest(1, 1, 1'b1);
        com_irq[1] = 1'b1;
        do_en(0, 33, 1'b1);
        check_irq("R9 routed to core1");
        chk(core_irq == 2'b10, "R9 only core1", core_irq, 2);
        do_ack(1, "R9 take 33");
        check_irq("R7 common active");
        do_eoi(0, 33);
        check_irq("R7 level re-presented");
        chk(core_irq[1] == 1'b1, "R7 again", core_irq[1], 1);
        do_dest(1, 1, 1'b0);
        check_irq("R9 delivery off");
        chk(core_irq == 2'b00, "R9 no core", core_irq, 0);
        do_dest(1, 0, 1'b1);
        do_pend(0, "R9 rerouted core0");
        com_irq[1] = 1'b0;
        check_irq("R9 level low");

        // R10: private level inputs stay on their own core
        do_en(0, 18, 1'b1);
        do_en(1, 18, 1'b1);
        priv_irq[2] = 1'b1;
        check_irq("R10 core0 private");
        chk(core_irq == 2'b01, "R10 only core0", core_irq, 1);
        do_ack(0, "R10 take 18");
        priv_irq[2] = 1'b0;
        do_eoi(0, 18);

        // R11: unmapped addresses
        wr(lbase(NC) + 'hA0, 32'd3);
        wr('h0004, 32'd0);
        rd(lbase(NC), v);              chk(v == 0, "R11 beyond cores", v, 0);
        rd('h0004, v);                 chk(v == 0, "R11 global hole", v, 0);
        rd(0, v);                      chk(v == 1, "R11 global kept", v, 1);
        rd(lbase(1), v);               chk(v == 1, "R11 local ctrl core1", v, 1);
        do_send(1, 9);
        do_en(0, 9, 1'b1);
        do_pend(0, "R11 state intact");
        do_ack(0, "R6 take 9");

        // Random mix checked against the model
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            int c  = $urandom_range(0, NC - 1);
            case (op)
                0: do_send($urandom_range(1, 3), $urandom_range(0, 15));
                1: do_en(c, $urandom_range(0, 43), 1'b1);
                2: do_en(c, $urandom_range(0, 43), ($urandom_range(0, 3) == 0));
                3: do_eoi(c, $urandom_range(0, 41));
                4, 5: do_ack(c, "R6 random ack");
                6: do_pend(c, "R8 random pending");
                7: begin
                    int k = $urandom_range(0, NCOM - 1);
                    com_irq[k] = ~com_irq[k];
                end
                8: begin
                    int b = $urandom_range(0, NC * 16 - 1);
                    priv_irq[b] = ~priv_irq[b];
                end
                default: do_dest($urandom_range(0, NCOM - 1), $urandom_range(0, 2),
                                 ($urandom_range(0, 3) != 0));
            endcase
            check_irq("R5 random request");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule